// File: doc/BRIEF.md
# Self-Synchronising TDM Serial Port

This block sits between two time-division PCM serial links and the byte-wide core of a multichannel voice processor. It runs on a bit clock with two clock cycles per data bit. Each frame carries 32 channel slots of 8 bits. Two serial streams come in, one on the receive side and one on the send side. Both are cut into bytes, and each byte is handed to the core together with its slot number. Two byte streams from the core are serialised back onto the receive-side and send-side outputs. All four streams share one frame and bit timing.

No setting is needed to choose the frame format. A single-clock frame pulse that goes low against a high idle level marks the MSB-first convention (format 0). A pulse that goes high against a low idle level marks the LSB-first convention (format 1). The block learns the format from the pulse itself and realigns its frame counter to every pulse it sees.

The core supplies output bytes one slot ahead. A fetch strobe names the slot it needs. The core answers in that same cycle.

The block also produces the enable for the two output pad buffers. Both pads float unless the enable pin and bit 6 of the control byte are both high.

Top module: `tdm_port`

## Requirements
- R1: While reset is high and in the first cycle after it, `slot_vld_o`, `fetch_o`, `lock_o` and `ser_oe_o` are 0.
- R2: A single-clock pulse that differs from the frame-pulse levels on both sides of it sets `lock_o` to 1 two clocks after the pulse is sampled. In that same cycle, `fmt_gci_o` takes the pulse level: 1 for a high pulse on a low idle line, 0 for a low pulse on a high idle line. `fmt_gci_o` changes only on such a pulse.
- R3: Counting the rising edge that samples the pulse as edge P, frame bit k (k = 0..255) is held on each input over edges P+3+2k and P+4+2k and captured on the second of them. Bits 8s..8s+7 make up slot s.
- R4: In format 0, the first bit of a slot is the byte's MSB. After the edge that captures a slot's last bit, `slot_vld_o` is high for exactly one cycle. In that cycle `slot_o` holds the slot number and `rin_byte_o` / `sin_byte_o` hold the two bytes.
- R5: In format 1, the first bit of a slot is the byte's LSB. Capture and strobe timing match R4.
- R6: Output bit k of a frame changes on the edge that ends input bit k-1 (bit 0 changes at the end of the previous frame). It is then stable over both edges of bit k. Within each slot the bit order is MSB first in format 0 and LSB first in format 1. Bytes on `rout_o` and `sout_o` are the ones the core supplied for that slot.
- R7: In the cycle after the edge that ends slot s, `fetch_o` is high for one cycle and `fetch_slot_o` = (s+2) mod 32. The core bytes present in that cycle are the ones sent in that slot.
- R8: One clock after the inputs change, `ser_oe_o` is high exactly when `ode_pin_i` is 1 and `ctrl_i[6]` is 1. The other control bits have no effect on it.
- R9: Before the first frame pulse after reset, `slot_vld_o` and `fetch_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, two cycles per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| fp_i | input | 1 | Frame pulse of either polarity |
| rin_i | input | 1 | Receive-side serial input |
| sin_i | input | 1 | Send-side serial input |
| ode_pin_i | input | 1 | Output drive enable pin |
| ctrl_i | input | 8 | Control byte; bit 6 enables output drive |
| rout_byte_i | input | 8 | Core byte for receive-side output, slot `fetch_slot_o` |
| sout_byte_i | input | 8 | Core byte for send-side output, slot `fetch_slot_o` |
| rin_byte_o | output | 8 | Byte captured from `rin_i` |
| sin_byte_o | output | 8 | Byte captured from `sin_i` |
| slot_o | output | 5 | Slot number of the captured bytes |
| slot_vld_o | output | 1 | One-cycle strobe for captured bytes |
| fetch_o | output | 1 | Request for output bytes |
| fetch_slot_o | output | 5 | Slot whose output bytes are requested |
| rout_o | output | 1 | Receive-side serial output data |
| sout_o | output | 1 | Send-side serial output data |
| ser_oe_o | output | 1 | Pad drive enable for both serial outputs |
| lock_o | output | 1 | Frame pulse seen since reset |
| fmt_gci_o | output | 1 | Detected format: 1 LSB-first, 0 MSB-first |

## Verification
The hardest state to reach from the ports is a full frame of output bits that can be checked. Output bytes pass through a fetch, a holding register and a shifter, so only the second frame after lock carries known data in every slot. The bench derives every serial input bit and every expected output bit from one edge counter anchored at the pulse. It runs three frames in each format, and the core model answers each fetch combinationally with a slot-dependent pattern. That lets the bench rebuild all 32 output bytes per lane without looking inside the design.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  typedef enum logic {
    FMT_MSB_FIRST = 1'b0,
    FMT_LSB_FIRST = 1'b1
  } fmt_e;
endpackage

// File: rtl/tdm_sync_det.sv
module tdm_sync_det (
  input  logic clk,
  input  logic rst,
  input  logic fp_i,
  output logic hit_o,
  output logic lvl_o
);
  logic [2:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else     hist_q <= {hist_q[1:0], fp_i};
  end

  // middle sample differs from both neighbours: a one-clock pulse
  assign hit_o = (hist_q[1] != hist_q[2]) && (hist_q[1] != hist_q[0]);
  assign lvl_o = hist_q[1];
endmodule

// File: rtl/tdm_timing.sv
module tdm_timing #(
  parameter int SLOTS = 32,
  parameter int BITS  = 8,
  parameter int CPB   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     hit_i,
  output logic [$clog2(SLOTS)-1:0] slot_o,
  output logic                     bit_end_o,
  output logic                     slot_end_o
);
  localparam int SW = $clog2(SLOTS);
  localparam int BW = $clog2(BITS);
  localparam int PW = (CPB > 1) ? $clog2(CPB) : 1;

  logic [PW-1:0] ph_q;
  logic [BW-1:0] bt_q;
  logic [SW-1:0] sl_q;

  assign bit_end_o  = (ph_q == PW'(CPB - 1));
  assign slot_end_o = bit_end_o && (bt_q == BW'(BITS - 1));
  assign slot_o     = sl_q;

  always_ff @(posedge clk) begin
    if (rst || hit_i) begin
      ph_q <= '0;
      bt_q <= '0;
      sl_q <= '0;
    end else if (!bit_end_o) begin
      ph_q <= ph_q + 1'b1;
    end else begin
      ph_q <= '0;
      if (bt_q != BW'(BITS - 1)) begin
        bt_q <= bt_q + 1'b1;
      end else begin
        bt_q <= '0;
        sl_q <= (sl_q == SW'(SLOTS - 1)) ? '0 : sl_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane
  import tdm_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  fmt_e            fmt_i,
  input  logic            sample_i,
  input  logic            last_i,
  input  logic            d_i,
  output logic [BITS-1:0] byte_o
);
  logic [BITS-1:0] sh_q;
  logic [BITS-1:0] nxt;

  always_comb begin
    if (fmt_i == FMT_LSB_FIRST) nxt = {d_i, sh_q[BITS-1:1]};
    else                        nxt = {sh_q[BITS-2:0], d_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      byte_o <= '0;
    end else if (sample_i) begin
      sh_q <= nxt;
      if (last_i) byte_o <= nxt;
    end
  end
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane
  import tdm_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  fmt_e            fmt_i,
  input  logic            take_i,
  input  logic [BITS-1:0] core_d_i,
  input  logic            adv_i,
  input  logic            new_slot_i,
  output logic            ser_o
);
  logic [BITS-1:0] hold_q;
  logic [BITS-1:0] sh_q;
  logic [BITS-1:0] nxt;

  always_comb begin
    if (new_slot_i)                  nxt = hold_q;
    else if (fmt_i == FMT_LSB_FIRST) nxt = sh_q >> 1;
    else                             nxt = sh_q << 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      sh_q   <= '0;
      ser_o  <= 1'b0;
    end else begin
      if (take_i) hold_q <= core_d_i;
      if (adv_i) begin
        sh_q  <= nxt;
        ser_o <= (fmt_i == FMT_LSB_FIRST) ? nxt[0] : nxt[BITS-1];
      end
    end
  end
endmodule

// File: rtl/tdm_port.sv
module tdm_port
  import tdm_pkg::*;
#(
  parameter int SLOTS       = 32,
  parameter int BITS        = 8,
  parameter int CPB         = 2,
  parameter int CTRL_OE_BIT = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fp_i,
  input  logic                     rin_i,
  input  logic                     sin_i,
  input  logic                     ode_pin_i,
  input  logic [7:0]               ctrl_i,
  input  logic [BITS-1:0]          rout_byte_i,
  input  logic [BITS-1:0]          sout_byte_i,
  output logic [BITS-1:0]          rin_byte_o,
  output logic [BITS-1:0]          sin_byte_o,
  output logic [$clog2(SLOTS)-1:0] slot_o,
  output logic                     slot_vld_o,
  output logic                     fetch_o,
  output logic [$clog2(SLOTS)-1:0] fetch_slot_o,
  output logic                     rout_o,
  output logic                     sout_o,
  output logic                     ser_oe_o,
  output logic                     lock_o,
  output logic                     fmt_gci_o
);
  localparam int SW    = $clog2(SLOTS);
  localparam int LANES = 2;

  logic          sync_hit, sync_lvl;
  logic          bit_end, slot_end;
  logic [SW-1:0] cur_slot;
  fmt_e          fmt_q;

  logic [LANES-1:0] rx_d;
  logic [BITS-1:0]  rx_byte [LANES];
  logic [BITS-1:0]  tx_core [LANES];
  logic [LANES-1:0] tx_ser;

  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl_i[7:CTRL_OE_BIT+1], ctrl_i[CTRL_OE_BIT-1:0]};

  tdm_sync_det sync_i (
    .clk   (clk),
    .rst   (rst),
    .fp_i  (fp_i),
    .hit_o (sync_hit),
    .lvl_o (sync_lvl)
  );

  tdm_timing #(.SLOTS(SLOTS), .BITS(BITS), .CPB(CPB)) tim_i (
    .clk        (clk),
    .rst        (rst),
    .hit_i      (sync_hit),
    .slot_o     (cur_slot),
    .bit_end_o  (bit_end),
    .slot_end_o (slot_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_o <= 1'b0;
      fmt_q  <= FMT_MSB_FIRST;
    end else if (sync_hit) begin
      lock_o <= 1'b1;
      fmt_q  <= sync_lvl ? FMT_LSB_FIRST : FMT_MSB_FIRST;
    end
  end
  assign fmt_gci_o = (fmt_q == FMT_LSB_FIRST);

  assign rx_d       = {sin_i, rin_i};
  assign tx_core[0] = rout_byte_i;
  assign tx_core[1] = sout_byte_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tdm_rx_lane #(.BITS(BITS)) rx_i (
      .clk      (clk),
      .rst      (rst),
      .fmt_i    (fmt_q),
      .sample_i (bit_end),
      .last_i   (slot_end),
      .d_i      (rx_d[g]),
      .byte_o   (rx_byte[g])
    );
    tdm_tx_lane #(.BITS(BITS)) tx_i (
      .clk        (clk),
      .rst        (rst),
      .fmt_i      (fmt_q),
      .take_i     (fetch_o),
      .core_d_i   (tx_core[g]),
      .adv_i      (bit_end),
      .new_slot_i (slot_end),
      .ser_o      (tx_ser[g])
    );
  end

  assign rin_byte_o = rx_byte[0];
  assign sin_byte_o = rx_byte[1];
  assign rout_o     = tx_ser[0];
  assign sout_o     = tx_ser[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_vld_o   <= 1'b0;
      slot_o       <= '0;
      fetch_o      <= 1'b0;
      fetch_slot_o <= '0;
      ser_oe_o     <= 1'b0;
    end else begin
      slot_vld_o <= slot_end && lock_o;
      fetch_o    <= slot_end && lock_o;
      ser_oe_o   <= ode_pin_i && ctrl_i[CTRL_OE_BIT];
      if (slot_end) begin
        slot_o       <= cur_slot;
        fetch_slot_o <= SW'((32'(cur_slot) + 2) % SLOTS);
      end
    end
  end
endmodule

// File: rtl/tdm_port_chk.sv
module tdm_port_chk #(
  parameter int SLOTS = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     hit,
  input logic                     vld,
  input logic                     fetch,
  input logic [$clog2(SLOTS)-1:0] slot,
  input logic [$clog2(SLOTS)-1:0] fetch_slot,
  input logic                     lock,
  input logic                     fmt
);
  localparam int SW = $clog2(SLOTS);

  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst) vld |=> !vld); // R4
  AST_VLD_LOCKED: assert property (@(posedge clk) disable iff (rst) vld |-> lock); // R9
  AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (rst) fetch |=> !fetch); // R7
  AST_FETCH_AHEAD: assert property (@(posedge clk) disable iff (rst)
    vld |-> (fetch && fetch_slot == SW'((32'(slot) + 2) % SLOTS))); // R7
  AST_FMT_HOLD: assert property (@(posedge clk) disable iff (rst) !hit |=> $stable(fmt)); // R2
endmodule

bind tdm_port tdm_port_chk #(.SLOTS(SLOTS)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .hit        (sync_hit),
  .vld        (slot_vld_o),
  .fetch      (fetch_o),
  .slot       (slot_o),
  .fetch_slot (fetch_slot_o),
  .lock       (lock_o),
  .fmt        (fmt_gci_o)
);

// File: tb/tdm_port_tb.sv
module tdm_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fp_i = 1'b1;
  logic       rin_i = 1'b0;
  logic       sin_i = 1'b0;
  logic       ode_pin_i = 1'b1;
  logic [7:0] ctrl_i = 8'h40;
  logic [7:0] rout_byte_i, sout_byte_i, rin_byte_o, sin_byte_o;
  logic [4:0] slot_o, fetch_slot_o;
  logic       slot_vld_o, fetch_o, rout_o, sout_o, ser_oe_o, lock_o, fmt_gci_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] rin_pat(int s);  return 8'(s * 29 + 3);      endfunction
  function automatic logic [7:0] sin_pat(int s);  return 8'((s * 53) ^ 198);  endfunction
  function automatic logic [7:0] rout_pat(int s); return 8'(s * 17 + 101);    endfunction
  function automatic logic [7:0] sout_pat(int s); return 8'((s * 71) ^ 90);   endfunction

  assign rout_byte_i = rout_pat(int'(fetch_slot_o));
  assign sout_byte_i = sout_pat(int'(fetch_slot_o));

  tdm_port dut_i (
    .clk(clk), .rst(rst), .fp_i(fp_i), .rin_i(rin_i), .sin_i(sin_i),
    .ode_pin_i(ode_pin_i), .ctrl_i(ctrl_i),
    .rout_byte_i(rout_byte_i), .sout_byte_i(sout_byte_i),
    .rin_byte_o(rin_byte_o), .sin_byte_o(sin_byte_o), .slot_o(slot_o),
    .slot_vld_o(slot_vld_o), .fetch_o(fetch_o), .fetch_slot_o(fetch_slot_o),
    .rout_o(rout_o), .sout_o(sout_o), .ser_oe_o(ser_oe_o),
    .lock_o(lock_o), .fmt_gci_o(fmt_gci_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input bit gci);
    @(negedge clk);
    rst = 1'b1;
    fp_i = !gci;
    rin_i = 1'b0;
    sin_i = 1'b0;
    repeat (4) @(negedge clk);
    check(slot_vld_o == 0 && fetch_o == 0, "R1 strobes in reset", int'(slot_vld_o), 0);
    check(lock_o == 0 && ser_oe_o == 0, "R1 lock/oe in reset", int'(lock_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(lock_o == 0 && slot_vld_o == 0, "R1 after release", int'(lock_o), 0);
  endtask

  // n indexes rising edges relative to the one sampling the frame pulse
  task automatic run_format(input bit gci, input int frames);
    logic [7:0] ra, sa;
    ra = '0;
    sa = '0;
    do_reset(gci);
    for (int n = -4; n < frames * 512 + 3; n++) begin
      bit act;
      int q, k, s, b;
      act = (n >= 0) && (n % 512 == 0);
      fp_i = gci ? act : !act;
      if (n >= 3) begin
        q = (n - 3) % 512; k = q / 2; s = k / 8; b = k % 8;
        rin_i = gci ? rin_pat(s)[b] : rin_pat(s)[7 - b];
        sin_i = gci ? sin_pat(s)[b] : sin_pat(s)[7 - b];
      end else begin
        rin_i = 1'b0;
        sin_i = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      if (n < 2) begin
        check(slot_vld_o == 0 && fetch_o == 0, "R9 quiet before pulse", int'(slot_vld_o), 0);
        if (n == 1) check(lock_o == 0, "R2 not locked yet", int'(lock_o), 0);
      end else if (n == 2) begin
        check(lock_o == 1, "R2 lock after pulse", int'(lock_o), 1);
        check(fmt_gci_o == gci, "R2 format detect", int'(fmt_gci_o), int'(gci));
      end else begin
        q = (n - 3) % 512; k = q / 2; s = k / 8; b = k % 8;
        if (q % 16 == 15) begin
          check(slot_vld_o == 1 && int'(slot_o) == q / 16, "R3 strobe slot", int'(slot_o), q / 16);
          check(rin_byte_o == rin_pat(q / 16), gci ? "R5 rin byte" : "R4 rin byte",
                int'(rin_byte_o), int'(rin_pat(q / 16)));
          check(sin_byte_o == sin_pat(q / 16), gci ? "R5 sin byte" : "R4 sin byte",
                int'(sin_byte_o), int'(sin_pat(q / 16)));
          check(fetch_o == 1 && int'(fetch_slot_o) == (q / 16 + 2) % 32, "R7 fetch slot",
                int'(fetch_slot_o), (q / 16 + 2) % 32);
        end else if (slot_vld_o || fetch_o) begin
          check(1'b0, "R4 strobe outside slot end", int'(slot_vld_o), 0);
        end
        if (n >= 515 && q % 2 == 0) begin
          if (gci) begin ra[b] = rout_o; sa[b] = sout_o; end
          else     begin ra[7 - b] = rout_o; sa[7 - b] = sout_o; end
          if (b == 7) begin
            check(ra == rout_pat(s), "R6 rout slot byte", int'(ra), int'(rout_pat(s)));
            check(sa == sout_pat(s), "R6 sout slot byte", int'(sa), int'(sout_pat(s)));
          end
        end
      end
    end
  endtask

  task automatic run_enable();
    logic [7:0] cv [4] = '{8'h00, 8'h40, 8'hBF, 8'hFF};
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 4; c++) begin
        ode_pin_i = p[0];
        ctrl_i = cv[c];
        repeat (2) @(negedge clk);
        check(ser_oe_o == (p[0] && cv[c][6]), "R8 drive enable",
              int'(ser_oe_o), int'(p[0] && cv[c][6]));
      end
    end
  endtask

  initial begin
    run_format(1'b0, 3);
    run_format(1'b1, 3);
    run_enable();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired, all requirements actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule